// File: doc/BRIEF.md
# Command-Response Buffer Register Front End

This block is the device-side register file of a command-response-buffer style security coprocessor. A host reaches it through one 32-bit memory-mapped slave port. The low part of the address space is a locality area. The control area follows it directly, at byte offset 0x40. Through these registers the host can:
- claim and release a locality;
- move the device between its ready and idle power states;
- launch a command and request that it be cancelled;
- read where the command and response buffers sit and how large they are.

The execution engine behind the block sees two levels: `eng_start_o`, which is high while a command is in flight, and `eng_cancel_o`, which follows the cancel bit. The engine ends a command by pulsing `eng_done_i`, or `eng_error_i` if the command failed. The host sees the end of a command because the start bit drops back to zero. An interrupt status bit also latches at that moment and can raise `irq_o`.

Host requests are acknowledged by the device itself. A ready or idle request bit stays set while the transition runs, which takes `TRANS_CYC` cycles, and then clears. The buffer addresses, the buffer sizes and the interface identifier are elaboration parameters.

Top module: `cmdbuf_regif`

## Requirements
- R1: Out of reset these registers read as follows:
  - locality state (0x00) reads 0x80, which is the register-valid flag only;
  - status (0x44) reads 0x2, meaning idle;
  - request (0x40), start (0x4C), cancel (0x48), interrupt enable (0x50) and interrupt status (0x54) read 0;
  - `irq_o`, `eng_start_o` and `eng_cancel_o` are low.
- R2: A write to locality control (0x08) behaves as follows:
  - bit 0 alone grants the locality, so locality state reads 0x82 (bit 1 assigned, bit 7 valid) and locality status (0x0C) bit 0 reads 1;
  - bit 1 alone releases it, so locality state reads 0x80 and locality status reads 0;
  - both bits together leave the grant unchanged.
- R3: Writing request (0x40) bit 0 (ready) or bit 1 (go-idle) sets that bit. The bit reads 1 for exactly `TRANS_CYC` cycles and then clears itself. At that same edge, status bit 1 (idle) becomes 0 for a ready request and 1 for a go-idle request.
- R4: Requests that overlap are resolved as follows:
  - a ready request written while go-idle is pending replaces it: bit 1 clears at once, the ready request completes normally, and the device ends non-idle;
  - a go-idle write while a ready request is pending is ignored;
  - a write with both bits set is treated as ready.
- R5: A write of 1 to start bit 0 (0x4C) is accepted only when the locality is assigned, the device is not idle and no command is busy. Once accepted, start reads 1 and `eng_start_o` is high. A write of 0 to start never clears the bit.
- R6: An `eng_done_i` or `eng_error_i` pulse while busy clears the start bit at that edge. `eng_error_i` also sets status bit 0 (error), which stays set until reset.
- R7: Cancel bit 0 (0x48) reads back the last value written and drives `eng_cancel_o`. It changes only when the host writes it.
- R8: The interrupt logic works as follows:
  - interrupt status bit 0 (0x54) sets at the edge where start falls, and a write of 1 to it clears it;
  - if a set and a clear meet in the same cycle, the set wins;
  - `irq_o` is high exactly when both interrupt enable bit 0 (0x50) and interrupt status bit 0 are 1.
- R9: The buffer registers read as follows:
  - command size (0x58), command address low and high (0x5C, 0x60) and response address low and high (0x68, 0x6C) return their parameter values;
  - response size (0x64) returns `RSP_SIZE` when the two buffer addresses differ;
  - when the two addresses are equal, response size returns `CMD_SIZE`.
- R10: The interface identifier reads low half at 0x30 and high half at 0x34. The control extension (0x38, 0x3C), every reserved offset and every write-only field read 0. Writes to read-only offsets change no register.
- R11: Read data appears on `bus_rdata` one cycle after the read strobe, and reads 0 in cycles without a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr_en | input | 1 | Write strobe, one cycle per word |
| bus_rd_en | input | 1 | Read strobe |
| bus_addr | input | ADDR_W | Byte address, word aligned |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| eng_start_o | output | 1 | Command in flight |
| eng_cancel_o | output | 1 | Cancel requested |
| eng_done_i | input | 1 | Engine finished the command |
| eng_error_i | input | 1 | Engine failed the command |
| irq_o | output | 1 | Completion interrupt |

## Verification
If the power-state counter is wrong, the request bits read back 1 for longer or shorter than `TRANS_CYC` cycles, and the idle flag in the status register flips at the wrong edge. A read taken just after the transition shows this. If the start gating is wrong, the start bit and `eng_start_o` rise on the write edge when they should not: with the locality released or the device idle. If completion tracking is wrong, the interrupt status fails to latch on the edge where start falls, so `irq_o` differs from its expected value in the very next cycle.

// File: rtl/cmdbuf_pkg.sv
package cmdbuf_pkg;

    localparam int unsigned DATA_W = 32;

    // word indices (byte offset / 4)
    localparam int W_LOC_STATE = 0;
    localparam int W_LOC_CTRL  = 2;
    localparam int W_LOC_STS   = 3;
    localparam int W_IFID_LO   = 12;
    localparam int W_IFID_HI   = 13;
    localparam int W_EXT_LO    = 14;
    localparam int W_EXT_HI    = 15;
    localparam int W_REQ       = 16;
    localparam int W_STS       = 17;
    localparam int W_CANCEL    = 18;
    localparam int W_START     = 19;
    localparam int W_INT_EN    = 20;
    localparam int W_INT_STS   = 21;
    localparam int W_CMD_SIZE  = 22;
    localparam int W_CMD_LO    = 23;
    localparam int W_CMD_HI    = 24;
    localparam int W_RSP_SIZE  = 25;
    localparam int W_RSP_LO    = 26;
    localparam int W_RSP_HI    = 27;

    // bit positions the host relies on
    localparam int B_LOC_ASSIGNED = 1;
    localparam int B_LOC_VALID    = 7;
    localparam int B_REQ_READY    = 0;
    localparam int B_REQ_IDLE     = 1;
    localparam int B_STS_ERR      = 0;
    localparam int B_STS_IDLE     = 1;

    typedef struct packed {
        logic assigned;
        logic valid;
    } loc_state_t;

    typedef struct packed {
        logic busy;
        logic cancel;
        logic err;
        logic int_en;
        logic int_sts;
    } exec_state_t;

endpackage

// File: rtl/cmdbuf_locality.sv
module cmdbuf_locality
    import cmdbuf_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic ctrl_wr,
    input  logic grant_bit,
    input  logic release_bit,
    output logic assigned,
    output logic valid
);

    loc_state_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.valid = 1'b1;
        if (ctrl_wr) begin
            if (grant_bit && !release_bit) begin
                st_d.assigned = 1'b1;
            end else if (release_bit && !grant_bit) begin
                st_d.assigned = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign assigned = st_q.assigned;
    assign valid    = st_q.valid;

endmodule

// File: rtl/cmdbuf_power.sv
module cmdbuf_power #(
    parameter int unsigned TRANS_CYC = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req_wr,
    input  logic ready_bit,
    input  logic idle_bit,
    output logic req_ready,
    output logic req_idle,
    output logic dev_idle
);

    localparam int unsigned CW = (TRANS_CYC < 2) ? 1 : $clog2(TRANS_CYC);
    localparam logic [CW-1:0] CNT_LOAD = CW'(TRANS_CYC - 1);

    typedef struct packed {
        logic          rdy;
        logic          idl;
        logic          idle;
        logic [CW-1:0] cnt;
    } pwr_t;

    pwr_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        // progress of a pending transition
        if (st_q.rdy || st_q.idl) begin
            if (st_q.cnt == '0) begin
                if (st_q.rdy) begin
                    st_d.rdy  = 1'b0;
                    st_d.idle = 1'b0;
                end else begin
                    st_d.idl  = 1'b0;
                    st_d.idle = 1'b1;
                end
            end else begin
                st_d.cnt = st_q.cnt - 1'b1;
            end
        end
        // new host request; ready overrides go-idle
        if (req_wr) begin
            if (ready_bit) begin
                st_d.rdy = 1'b1;
                st_d.idl = 1'b0;
                st_d.cnt = CNT_LOAD;
            end else if (idle_bit && !st_q.rdy) begin
                st_d.idl = 1'b1;
                st_d.cnt = CNT_LOAD;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.idle <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign req_ready = st_q.rdy;
    assign req_idle  = st_q.idl;
    assign dev_idle  = st_q.idle;

endmodule

// File: rtl/cmdbuf_exec.sv
module cmdbuf_exec
    import cmdbuf_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start_wr,
    input  logic start_bit,
    input  logic cancel_wr,
    input  logic cancel_bit,
    input  logic inten_wr,
    input  logic inten_bit,
    input  logic intclr_wr,
    input  logic intclr_bit,
    input  logic loc_assigned,
    input  logic dev_idle,
    input  logic eng_done,
    input  logic eng_error,
    output logic busy,
    output logic cancel,
    output logic err,
    output logic int_en,
    output logic int_sts,
    output logic irq
);

    exec_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (cancel_wr) begin
            st_d.cancel = cancel_bit;
        end
        if (inten_wr) begin
            st_d.int_en = inten_bit;
        end
        if (intclr_wr && intclr_bit) begin
            st_d.int_sts = 1'b0;
        end
        if (eng_error) begin
            st_d.err = 1'b1;
        end
        if (st_q.busy && (eng_done || eng_error)) begin
            st_d.busy = 1'b0;
        end
        if (start_wr && start_bit && !st_q.busy && loc_assigned && !dev_idle) begin
            st_d.busy = 1'b1;
        end
        // completion latches the interrupt; set beats a same-cycle clear
        if (st_q.busy && !st_d.busy) begin
            st_d.int_sts = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign busy    = st_q.busy;
    assign cancel  = st_q.cancel;
    assign err     = st_q.err;
    assign int_en  = st_q.int_en;
    assign int_sts = st_q.int_sts;
    assign irq     = st_q.int_en & st_q.int_sts;

endmodule

// File: rtl/cmdbuf_readmux.sv
module cmdbuf_readmux
    import cmdbuf_pkg::*;
#(
    parameter int unsigned WORD_W   = 5,
    parameter logic [63:0] IF_ID    = 64'h0,
    parameter logic [63:0] CMD_ADDR = 64'h0,
    parameter logic [31:0] CMD_SIZE = 32'h0,
    parameter logic [63:0] RSP_ADDR = 64'h0,
    parameter logic [31:0] RSP_SIZE = 32'h0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_en,
    input  logic [WORD_W-1:0] word,
    input  logic              loc_assigned,
    input  logic              loc_valid,
    input  logic              req_ready,
    input  logic              req_idle,
    input  logic              dev_idle,
    input  logic              err,
    input  logic              busy,
    input  logic              cancel,
    input  logic              int_en,
    input  logic              int_sts,
    output logic [DATA_W-1:0] rdata
);

    logic [DATA_W-1:0] rsp_size_rep;

    generate
        if (CMD_ADDR == RSP_ADDR) begin : g_shared_buf
            assign rsp_size_rep = CMD_SIZE;
        end else begin : g_split_buf
            assign rsp_size_rep = RSP_SIZE;
        end
    endgenerate

    logic [DATA_W-1:0] rdata_d, rdata_q, mux;

    always_comb begin
        mux = '0;
        case (int'(word))
            W_LOC_STATE: begin
                mux[B_LOC_ASSIGNED] = loc_assigned;
                mux[B_LOC_VALID]    = loc_valid;
            end
            W_LOC_STS:   mux[0] = loc_assigned;
            W_IFID_LO:   mux = IF_ID[31:0];
            W_IFID_HI:   mux = IF_ID[63:32];
            W_REQ: begin
                mux[B_REQ_READY] = req_ready;
                mux[B_REQ_IDLE]  = req_idle;
            end
            W_STS: begin
                mux[B_STS_ERR]  = err;
                mux[B_STS_IDLE] = dev_idle;
            end
            W_CANCEL:    mux[0] = cancel;
            W_START:     mux[0] = busy;
            W_INT_EN:    mux[0] = int_en;
            W_INT_STS:   mux[0] = int_sts;
            W_CMD_SIZE:  mux = CMD_SIZE;
            W_CMD_LO:    mux = CMD_ADDR[31:0];
            W_CMD_HI:    mux = CMD_ADDR[63:32];
            W_RSP_SIZE:  mux = rsp_size_rep;
            W_RSP_LO:    mux = RSP_ADDR[31:0];
            W_RSP_HI:    mux = RSP_ADDR[63:32];
            default:     mux = '0;
        endcase
        rdata_d = rd_en ? mux : '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_q <= '0;
        end else begin
            rdata_q <= rdata_d;
        end
    end

    assign rdata = rdata_q;

endmodule

// File: rtl/cmdbuf_regif.sv
module cmdbuf_regif
    import cmdbuf_pkg::*;
#(
    parameter int unsigned ADDR_W    = 7,
    parameter int unsigned TRANS_CYC = 4,
    parameter logic [63:0] IF_ID     = 64'h0000_00A5_0001_4321,
    parameter logic [63:0] CMD_ADDR  = 64'h0000_0001_8000_0080,
    parameter logic [31:0] CMD_SIZE  = 32'h0000_0F80,
    parameter logic [63:0] RSP_ADDR  = 64'h0000_0001_8000_0080,
    parameter logic [31:0] RSP_SIZE  = 32'h0000_0800
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr_en,
    input  logic              bus_rd_en,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              eng_start_o,
    output logic              eng_cancel_o,
    input  logic              eng_done_i,
    input  logic              eng_error_i,
    output logic              irq_o
);

    localparam int unsigned WORD_W    = ADDR_W - 2;
    localparam int unsigned NUM_WORDS = 1 << WORD_W;

    logic [WORD_W-1:0]    word;
    logic [NUM_WORDS-1:0] wr_sel;

    assign word = bus_addr[ADDR_W-1:2];

    generate
        for (genvar i = 0; i < NUM_WORDS; i++) begin : g_wdec
            assign wr_sel[i] = bus_wr_en && (word == WORD_W'(i));
        end
    endgenerate

    logic loc_assigned, loc_valid;
    logic req_wr, req_ready, req_idle, dev_idle;
    logic busy, cancel_wr, err, int_en, int_sts;

    assign req_wr    = wr_sel[W_REQ];
    assign cancel_wr = wr_sel[W_CANCEL];

    cmdbuf_locality u_loc (
        .clk         (clk),
        .rst_n       (rst_n),
        .ctrl_wr     (wr_sel[W_LOC_CTRL]),
        .grant_bit   (bus_wdata[0]),
        .release_bit (bus_wdata[1]),
        .assigned    (loc_assigned),
        .valid       (loc_valid)
    );

    cmdbuf_power #(.TRANS_CYC(TRANS_CYC)) u_pwr (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_wr    (req_wr),
        .ready_bit (bus_wdata[B_REQ_READY]),
        .idle_bit  (bus_wdata[B_REQ_IDLE]),
        .req_ready (req_ready),
        .req_idle  (req_idle),
        .dev_idle  (dev_idle)
    );

    cmdbuf_exec u_exec (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_wr     (wr_sel[W_START]),
        .start_bit    (bus_wdata[0]),
        .cancel_wr    (cancel_wr),
        .cancel_bit   (bus_wdata[0]),
        .inten_wr     (wr_sel[W_INT_EN]),
        .inten_bit    (bus_wdata[0]),
        .intclr_wr    (wr_sel[W_INT_STS]),
        .intclr_bit   (bus_wdata[0]),
        .loc_assigned (loc_assigned),
        .dev_idle     (dev_idle),
        .eng_done     (eng_done_i),
        .eng_error    (eng_error_i),
        .busy         (busy),
        .cancel       (eng_cancel_o),
        .err          (err),
        .int_en       (int_en),
        .int_sts      (int_sts),
        .irq          (irq_o)
    );

    cmdbuf_readmux #(
        .WORD_W   (WORD_W),
        .IF_ID    (IF_ID),
        .CMD_ADDR (CMD_ADDR),
        .CMD_SIZE (CMD_SIZE),
        .RSP_ADDR (RSP_ADDR),
        .RSP_SIZE (RSP_SIZE)
    ) u_rd (
        .clk          (clk),
        .rst_n        (rst_n),
        .rd_en        (bus_rd_en),
        .word         (word),
        .loc_assigned (loc_assigned),
        .loc_valid    (loc_valid),
        .req_ready    (req_ready),
        .req_idle     (req_idle),
        .dev_idle     (dev_idle),
        .err          (err),
        .busy         (busy),
        .cancel       (eng_cancel_o),
        .int_en       (int_en),
        .int_sts      (int_sts),
        .rdata        (bus_rdata)
    );

    assign eng_start_o = busy;

    logic in_unused;
    assign in_unused = ^{bus_wdata[31:2], bus_addr[1:0], wr_sel};

endmodule

// File: rtl/cmdbuf_regif_chk.sv
module cmdbuf_regif_chk #(
    parameter int unsigned TRANS_CYC = 4
) (
    input logic clk,
    input logic rst_n,
    input logic loc_assigned,
    input logic loc_valid,
    input logic req_wr,
    input logic req_ready,
    input logic req_idle,
    input logic dev_idle,
    input logic busy,
    input logic err,
    input logic int_sts,
    input logic int_en,
    input logic irq,
    input logic cancel_wr,
    input logic eng_cancel
);

    int unsigned pend_cnt;

    always_ff @(posedge clk) begin
        if (!rst_n || req_wr || !(req_ready || req_idle)) begin
            pend_cnt <= 0;
        end else begin
            pend_cnt <= pend_cnt + 1;
        end
    end

    p_grant_valid_r2: assert property (@(posedge clk) disable iff (!rst_n)
        loc_assigned |-> loc_valid);

    p_req_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_ready || req_idle) |-> (pend_cnt < TRANS_CYC));

    p_ready_done_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(req_ready) |-> !dev_idle);

    p_idle_done_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(req_idle) && !req_ready) |-> dev_idle);

    p_req_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({req_ready, req_idle}));

    p_start_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> ($past(loc_assigned) && !$past(dev_idle)));

    p_err_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $past(err) |-> err);

    p_cancel_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(cancel_wr) |-> $stable(eng_cancel));

    p_int_on_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> int_sts);

    p_irq_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (int_en && int_sts));

endmodule

bind cmdbuf_regif cmdbuf_regif_chk #(.TRANS_CYC(TRANS_CYC)) chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .loc_assigned (loc_assigned),
    .loc_valid    (loc_valid),
    .req_wr       (req_wr),
    .req_ready    (req_ready),
    .req_idle     (req_idle),
    .dev_idle     (dev_idle),
    .busy         (busy),
    .err          (err),
    .int_sts      (int_sts),
    .int_en       (int_en),
    .irq          (irq_o),
    .cancel_wr    (cancel_wr),
    .eng_cancel   (eng_cancel_o)
);

// File: tb/cmdbuf_regif_tb_top.sv
`timescale 1ns/1ps
module cmdbuf_regif_tb_top;

    localparam int          TRANS  = 4;
    localparam logic [63:0] E_IFID = 64'h0000_00A5_0001_4321;
    localparam logic [63:0] E_CMDA = 64'h0000_0001_8000_0080;
    localparam logic [31:0] E_CMDS = 32'h0000_0F80;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr_en = 1'b0;
    logic        bus_rd_en = 1'b0;
    logic [6:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        eng_start_o, eng_cancel_o, irq_o;
    logic        eng_done_i = 1'b0;
    logic        eng_error_i = 1'b0;

    int n_checks = 0;
    int n_fail   = 0;

    // bench model
    logic m_assigned = 0, m_idle = 1, m_busy = 0, m_cancel = 0;
    logic m_err = 0, m_inten = 0, m_intsts = 0;

    always #10 clk = ~clk;

    cmdbuf_regif dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .bus_wr_en    (bus_wr_en),
        .bus_rd_en    (bus_rd_en),
        .bus_addr     (bus_addr),
        .bus_wdata    (bus_wdata),
        .bus_rdata    (bus_rdata),
        .eng_start_o  (eng_start_o),
        .eng_cancel_o (eng_cancel_o),
        .eng_done_i   (eng_done_i),
        .eng_error_i  (eng_error_i),
        .irq_o        (irq_o)
    );

    function automatic logic [31:0] exp_word(int w);
        logic [31:0] v = '0;
        case (w)
            0:  begin v[1] = m_assigned; v[7] = 1'b1; end
            3:  v[0] = m_assigned;
            12: v = E_IFID[31:0];
            13: v = E_IFID[63:32];
            17: begin v[0] = m_err; v[1] = m_idle; end
            18: v[0] = m_cancel;
            19: v[0] = m_busy;
            20: v[0] = m_inten;
            21: v[0] = m_intsts;
            22: v = E_CMDS;
            23: v = E_CMDA[31:0];
            24: v = E_CMDA[63:32];
            25: v = E_CMDS;
            26: v = E_CMDA[31:0];
            27: v = E_CMDA[63:32];
            default: v = '0;
        endcase
        return v;
    endfunction

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // tasks start and end at a falling edge
    task automatic wr(int w, logic [31:0] d);
        bus_wr_en = 1'b1; bus_addr = 7'(w * 4); bus_wdata = d;
        @(negedge clk);
        bus_wr_en = 1'b0;
    endtask

    task automatic rd(int w, output logic [31:0] d);
        bus_rd_en = 1'b1; bus_addr = 7'(w * 4);
        @(negedge clk);
        bus_rd_en = 1'b0;
        d = bus_rdata;
    endtask

    task automatic rd_chk(string tag, int w, logic [31:0] exp);
        logic [31:0] d;
        rd(w, d);
        check(tag, d, exp);
    endtask

    task automatic wait_cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_done(logic is_err);
        if (is_err) eng_error_i = 1'b1; else eng_done_i = 1'b1;
        @(negedge clk);
        eng_error_i = 1'b0; eng_done_i = 1'b0;
    endtask

    task automatic report;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        report();
        $finish;
    end

    initial begin
        logic [31:0] d;
        void'($urandom(32'd2024));
        wait_cyc(3);
        check("R1 irq in reset", {31'd0, irq_o}, 32'd0);
        rst_n = 1'b1;
        wait_cyc(2);
        // R1 reset state
        rd_chk("R1 loc state", 0, 32'h80);
        rd_chk("R1 status", 17, 32'h2);
        rd_chk("R1 request", 16, 32'h0);
        rd_chk("R1 start", 19, 32'h0);
        rd_chk("R1 cancel", 18, 32'h0);
        rd_chk("R1 int sts", 21, 32'h0);
        check("R1 pins", {29'd0, eng_start_o, eng_cancel_o, irq_o}, 32'd0);
        // R11 no read -> zero
        @(negedge clk);
        check("R11 idle rdata", bus_rdata, 32'd0);

        // constrained random: locality, cancel, enable, ignored writes, reads
        for (int it = 0; it < 300; it++) begin
            int op = int'($urandom_range(0, 5));
            case (op)
                0: begin wr(2, 32'h1); m_assigned = 1; end
                1: begin wr(2, 32'h2); m_assigned = 0; end
                2: wr(2, 32'h3);  // R2 both bits: no change
                3: begin
                    logic b = 1'($urandom_range(0, 1));
                    wr(18, {$urandom} & 32'hFFFF_FFFE | {31'd0, b});
                    m_cancel = b;
                    check("R7 cancel pin", {31'd0, eng_cancel_o}, {31'd0, m_cancel});
                end
                4: begin
                    int ro[19] = '{0, 1, 3, 4, 5, 8, 11, 12, 13, 14, 15, 17, 22, 23, 24, 25, 26, 27, 30};
                    wr(ro[$urandom_range(0, 18)], $urandom);  // R10 ignored
                end
                default: begin
                    int w = int'($urandom_range(0, 31));
                    rd(w, d);
                    check($sformatf("R10 random read word %0d (R2 R7 R9)", w), d, exp_word(w));
                end
            endcase
        end
        for (int w = 0; w < 32; w++) begin
            rd(w, d);
            check($sformatf("R9 R10 sweep word %0d", w), d, exp_word(w));
        end

        // normalise
        wr(2, 32'h1); m_assigned = 1;
        wr(18, 32'h0); m_cancel = 0;
        wr(20, 32'h0); m_inten = 0;
        rd_chk("R2 granted", 0, 32'h82);
        rd_chk("R2 loc sts", 3, 32'h1);

        // R5 start refused while idle
        wr(19, 32'h1);
        check("R5 start blocked idle", {31'd0, eng_start_o}, 32'd0);
        rd_chk("R5 start reads 0 idle", 19, 32'h0);

        // R3 ready handshake
        wr(16, 32'h1);
        rd_chk("R3 ready pending", 16, 32'h1);
        wait_cyc(TRANS + 2);
        rd_chk("R3 ready cleared", 16, 32'h0);
        rd_chk("R3 not idle", 17, 32'h0);

        // R5 start refused without locality
        wr(2, 32'h2); m_assigned = 0;
        wr(19, 32'h1);
        rd_chk("R5 start blocked no loc", 19, 32'h0);
        wr(2, 32'h1); m_assigned = 1;
        wr(19, 32'h1);
        check("R5 eng start", {31'd0, eng_start_o}, 32'd1);
        wr(19, 32'h0);
        rd_chk("R5 zero write ignored", 19, 32'h1);

        // R6 done, R8 interrupt
        pulse_done(1'b0);
        check("R6 start cleared by done", {31'd0, eng_start_o}, 32'd0);
        check("R8 irq masked", {31'd0, irq_o}, 32'd0);
        rd_chk("R8 int sts set", 21, 32'h1);
        wr(20, 32'h1);
        check("R8 irq raised", {31'd0, irq_o}, 32'd1);
        wr(21, 32'h1);
        check("R8 irq cleared W1C", {31'd0, irq_o}, 32'd0);

        // R8 set wins over same-cycle clear
        wr(19, 32'h1);
        bus_wr_en = 1'b1; bus_addr = 7'(21 * 4); bus_wdata = 32'h1; eng_done_i = 1'b1;
        @(negedge clk);
        bus_wr_en = 1'b0; eng_done_i = 1'b0;
        check("R8 set beats clear", {31'd0, irq_o}, 32'd1);
        wr(21, 32'h1);

        // R6 error completion
        wr(19, 32'h1);
        pulse_done(1'b1);
        check("R6 start cleared by error", {31'd0, eng_start_o}, 32'd0);
        rd_chk("R6 error flag", 17, 32'h1);

        // R4 ready replaces pending go-idle
        wr(16, 32'h2);
        rd_chk("R4 go-idle pending", 16, 32'h2);
        wr(16, 32'h1);
        rd_chk("R4 ready replaces", 16, 32'h1);
        wait_cyc(TRANS + 2);
        rd_chk("R4 ready done", 16, 32'h0);
        rd_chk("R4 not idle, R6 err sticky", 17, 32'h1);
        // R3 go-idle completes
        wr(16, 32'h2);
        wait_cyc(TRANS + 2);
        rd_chk("R3 go-idle done", 17, 32'h3);
        // R4 go-idle ignored during ready
        wr(16, 32'h1);
        wr(16, 32'h2);
        rd_chk("R4 go-idle ignored", 16, 32'h1);
        wait_cyc(TRANS + 2);
        rd_chk("R4 ends ready", 17, 32'h1);
        // R4 both bits act as ready
        wr(16, 32'h2);
        wait_cyc(TRANS + 2);
        wr(16, 32'h3);
        rd_chk("R4 both bits ready", 16, 32'h1);

        // R7 cancel pin
        wr(18, 32'h1);
        check("R7 cancel high", {31'd0, eng_cancel_o}, 32'd1);
        wr(18, 32'h0);
        check("R7 cancel low", {31'd0, eng_cancel_o}, 32'd0);

        report();
        $finish;
    end

endmodule